// File: doc/BRIEF.md
# Bit-Serial Fourth-Order Comb Cascade

This block is the decimated-rate back end of a fourth-order sinc decimator. Each word taken from the integrator chain passes through four differencing stages in series. Each stage emits its present input minus the input it held at the previous decimated sample, all modulo 2^24, and then keeps the present input for the next sample. The arithmetic is bit-serial: each stage has a one-bit subtractor with a borrow flop and a 24-bit history shift register. The four stages are chained combinationally bit by bit, so one bit of every stage is settled in each clock.

A word is taken over a valid/ready handshake. Upstream presents `in_word` with `in_valid` and must hold both until a cycle in which `in_ready` is also high. The block accepts on that clock edge. After that it can accept one word every 32 clocks, which matches a decimation factor of 32. `in_ready` stays low while a word is being streamed. A word offered during that time waits and is not lost. The final difference leaves on `ser_data` one bit per clock, least significant bit first, followed by eight zero pad bits. `ser_fs` marks the least significant bit. The output has no back-pressure.

Top module: `comb_serial_cascade`

## Requirements
- R1: After reset `ser_data` and `ser_fs` are 0 and `in_ready` is 1, and all four stage histories are zero, so the first word after reset comes out unchanged.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for the next 31 cycles and returns to 1 in the 32nd cycle, so back-to-back words are 32 clocks apart. While `in_ready` is 0, `in_valid` and `in_word` have no effect on any output.
- R3: Each stage k outputs (input_k − held_k) mod 2^24 and then holds input_k. The borrow into bit 0 is 0, and the borrow out of bit 23 is dropped.
- R4: Stage 1 takes the accepted word, stages 2 to 4 take the previous stage's output, and the streamed word is stage 4's output.
- R5: Bit i (i = 0..23) of the result is on `ser_data` in the cycle that follows the (i+1)-th rising edge after the accepting edge.
- R6: `ser_fs` is 1 only in the cycle that carries bit 0 and is 0 in every other cycle.
- R7: `ser_data` is 0 for frame positions 24 to 31 and whenever no word is streaming.
- R8: The result is the 24-bit two's-complement difference, so negative differences and wraparound of the inputs give the modular result.
- R9: Words accepted back-to-back give frames with no gap between them. The `ser_fs` of one frame follows the last pad bit of the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the integrator chain |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word is present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_word | input | 24 | Decimated integrator word |
| ser_data | output | 1 | Serial result, LSB first |
| ser_fs | output | 1 | High in the cycle carrying the LSB |

## Verification
The first output bit is due one edge after the accepting edge, because it goes through the output register only. Bit i is due i edges after that, and `in_ready` returns 31 edges after acceptance. The bench samples on falling edges. It logs the edge number of each acceptance and requires each `ser_fs` to arrive exactly one edge later. It then assembles the 24 bits that follow by frame position and compares them with a four-stage difference model that is updated in acceptance order. It counts the cycles of low `in_ready` between back-to-back words and checks that pad and idle cycles stay zero.

// File: rtl/comb_cascade_pkg.sv
package comb_cascade_pkg;
  localparam int unsigned CC_WORD_W    = 24;
  localparam int unsigned CC_FRAME_LEN = 32;
  localparam int unsigned CC_STAGES    = 4;
endpackage

// File: rtl/comb_frame_seq.sv
module comb_frame_seq #(
  parameter int unsigned WORD_W    = 24,
  parameter int unsigned FRAME_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic busy,
  output logic bit_en,
  output logic word_start
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] pos_q;
  logic             busy_q;

  assign in_ready   = !busy_q || (pos_q == LAST_POS);
  assign accept     = in_valid && in_ready;
  assign busy       = busy_q;
  assign bit_en     = busy_q && (pos_q <= LAST_DATA);
  assign word_start = busy_q && (pos_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      busy_q <= 1'b0;
    end else if (accept) begin
      pos_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (pos_q == LAST_POS) busy_q <= 1'b0;
      else                   pos_q  <= pos_q + 1'b1;
    end
  end

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !accept && pos_q != LAST_POS) |=> (busy_q && pos_q == $past(pos_q) + 1'b1));
endmodule

// File: rtl/comb_bit_stage.sv
module comb_bit_stage #(
  parameter int unsigned WORD_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic word_start,
  input  logic a_bit,
  output logic d_bit
);
  logic [WORD_W-1:0] hist_q;
  logic              brw_q;
  logic              s_bit, b_in, b_out;

  assign s_bit = hist_q[0];
  assign b_in  = word_start ? 1'b0 : brw_q;
  assign d_bit = a_bit ^ s_bit ^ b_in;
  assign b_out = (~a_bit & s_bit) | (~(a_bit ^ s_bit) & b_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      brw_q  <= 1'b0;
    end else if (bit_en) begin
      hist_q <= {a_bit, hist_q[WORD_W-1:1]};
      brw_q  <= b_out;
    end
  end

  // R3
  hist_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (hist_q[WORD_W-1] == $past(a_bit)));
  // R3
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(hist_q));
endmodule

// File: rtl/comb_serial_cascade.sv
module comb_serial_cascade
  import comb_cascade_pkg::*;
#(
  parameter int unsigned WORD_W    = CC_WORD_W,
  parameter int unsigned FRAME_LEN = CC_FRAME_LEN,
  parameter int unsigned STAGES    = CC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              ser_data,
  output logic              ser_fs
);
  logic accept, busy, bit_en, word_start;
  logic [WORD_W-1:0] in_sr_q;
  logic [STAGES:0]   chain;
  logic              data_q, fs_q;

  comb_frame_seq #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .busy(busy), .bit_en(bit_en), .word_start(word_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      in_sr_q <= '0;
    else if (accept) in_sr_q <= in_word;
    else if (bit_en) in_sr_q <= in_sr_q >> 1;
  end

  assign chain[0] = in_sr_q[0];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    comb_bit_stage #(.WORD_W(WORD_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_start(word_start),
      .a_bit(chain[g]), .d_bit(chain[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      data_q <= bit_en & chain[STAGES];
      fs_q   <= word_start;
    end
  end

  assign ser_data = data_q;
  assign ser_fs   = fs_q;

  // R6
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_fs |=> !ser_fs);
  // R7
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> !ser_data);
  // R5
  fs_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 ser_fs);
endmodule

// File: tb/comb_serial_cascade_tb.sv
module comb_serial_cascade_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic in_ready, ser_data, ser_fs;

  comb_serial_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .ser_data(ser_data), .ser_fs(ser_fs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [W-1:0] hist [4];
  logic [W-1:0] exp_q [$];
  int acc_q [$];
  logic monitor_on = 1'b0;
  int frames = 0, sent = 0;
  logic idle_bad = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] model_step(input logic [W-1:0] x);
    logic [W-1:0] v = x, d;
    for (int k = 0; k < 4; k++) begin
      d = v - hist[k];
      hist[k] = v;
      v = d;
    end
    return v;
  endfunction

  // R2: returns number of low-ready cycles waited
  task automatic send(input logic [W-1:0] w, input bit junk, output int waits);
    waits = 0;
    in_valid = junk;
    while (!in_ready) begin
      if (junk) in_word = W'($urandom);
      waits++;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_word = w;
    exp_q.push_back(model_step(w));
    acc_q.push_back(cyc + 1);
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  int pos = 32;
  logic in_frame = 1'b0;
  logic [W-1:0] got;
  logic pad_bad;
  always @(negedge clk) begin
    if (monitor_on) begin
      if (ser_fs) begin
        int a;
        // R9: previous frame must be complete
        if (in_frame) check(pos == 32, "R9 frame gap", pos, 32);
        a = (acc_q.size() > 0) ? acc_q.pop_front() : -1;
        // R5 / R6: frame sync one edge after acceptance
        check(cyc == a + 1, "R5/R6 fs timing", cyc, a + 1);
        in_frame = 1'b1; pos = 1; got = '0; got[0] = ser_data; pad_bad = 1'b0;
      end else if (in_frame) begin
        if (pos < W) got[pos] = ser_data;
        else if (ser_data) pad_bad = 1'b1;
        if (pos == W - 1) begin
          logic [W-1:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
          // R3 R4 R8: four-stage modular difference
          check(got == e, "R3/R4/R8 word", got, e);
          frames++;
        end
        pos++;
        if (pos == 32) begin
          // R7: pad bits zero
          check(!pad_bad, "R7 pad", pad_bad, 0);
          in_frame = 1'b0;
        end
      end else if (ser_data) idle_bad = 1'b1;
    end
  end

  initial begin
    repeat (400 * 40) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int wt;
    logic [W-1:0] acc1, acc2, acc3, acc4;
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) hist[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(ser_data == 0 && ser_fs == 0, "R1 outputs in reset", {ser_data, ser_fs}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    check(ser_data == 0 && ser_fs == 0, "R1 outputs idle", {ser_data, ser_fs}, 0);
    monitor_on = 1'b1;
    // R1: zero history, first word passes unchanged
    send(24'h123456, 1'b0, wt);
    check(exp_q[0] == 24'h123456, "R1 model first word", exp_q[0], 24'h123456);
    // R9 / R2: back-to-back, ready low 31 cycles
    send(24'h000005, 1'b0, wt);
    check(wt == 31, "R2 ready low window", wt, 31);
    // R8: negative differences and wrap
    send(24'h000000, 1'b0, wt);
    send(24'hFFFFFF, 1'b0, wt);
    send(24'h800000, 1'b0, wt);
    send(24'h7FFFFF, 1'b0, wt);
    check(wt == 31, "R9 back-to-back spacing", wt, 31);
    // R2: junk offered while not ready is ignored
    for (int i = 0; i < 6; i++) send(W'($urandom), 1'b1, wt);
    // gaps between words
    for (int i = 0; i < 8; i++) begin
      repeat ($urandom_range(0, 9)) @(negedge clk);
      send(W'($urandom), 1'b0, wt);
    end
    // integrator-like stream: four cascaded sums of a small random input
    acc1 = '0; acc2 = '0; acc3 = '0; acc4 = '0;
    for (int i = 0; i < 40; i++) begin
      for (int t = 0; t < 32; t++) begin
        acc1 = acc1 + W'($urandom_range(0, 15));
        acc2 = acc2 + acc1; acc3 = acc3 + acc2; acc4 = acc4 + acc3;
      end
      send(acc4, (i % 3) == 0, wt);
    end
    // random words
    for (int i = 0; i < 30; i++) send(W'($urandom), 1'b0, wt);
    repeat (40) @(negedge clk);
    // R7: idle output stays zero
    check(!idle_bad, "R7 idle zero", idle_bad, 0);
    check(frames == sent, "R5 all frames seen", frames, sent);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule